// File: doc/BRIEF.md
# SD Command Issue and Response Capture

This block takes a 16-bit command word written by the host side, splits it into its fields, and, when the controller is enabled, hands the command index and a 32-bit argument to the card side through a request/response handshake. When the card answers, the block compares the number of returned bytes with the number that the response type needs. It stores the reply in eight 16-bit response registers and produces one-cycle status set/clear masks. A separate status register, outside this block, applies those masks.

A command whose type is the data-transfer type also produces a start pulse with a direction for the data path. Any other command produces a stop pulse that ends a transfer already running. An initialisation pseudo-command with index 0 never reaches the card; it completes at once. CRC checking, timeout counting in clock cycles and the serial CMD line are handled elsewhere.

Top module: `sdcmd_issuer`

## Requirements
- R1: Command word fields: index in bits 5:0, init flag in bit 7, response code in bits 10:8 (0 none, 1 short status, 2 long 16-byte, 3 operating conditions, 6 published address; any other code is handled as none), busy flag in bit 11, command type in bits 13:12 (3 means data transfer), direction in bit 15. Bits 6 and 14 are ignored.
- R2: A `cmd_wr` pulse is ignored while `ctrl_en` is low or while a command is outstanding (`busy` high). An ignored write produces no card request and no completion, and it leaves `rsp_word` unchanged.
- R3: An accepted command clears all response registers. In the cycle after `cmd_wr` it raises `card_req` for exactly one cycle, with `card_idx` and `card_arg` carrying the index and argument.
- R4: With the init flag set and index 0, no card request is made. `cmd_done` rises in the cycle after `cmd_wr`, with `sts_set`=0x0001 and `sts_clr`=0x0000 and no transfer pulse.
- R5: Response code 1 with the busy flag set is promoted to the busy-status variant. The expected length is 0 bytes for none, 16 for code 2, and 4 for codes 1 (with or without busy), 3 and 6. If `card_rsp_len` is below the expected length, `sts_set` bit 7 is set instead of bit 0 and the response registers stay zero.
- R6: For code 1 (with or without busy), the first four reply bytes, taken big-endian, are ANDed with the error mask (default 32'hFDF9_0000). A nonzero result sets bit 14. Every other non-init completion puts bit 14 in `sts_clr`.
- R7: For code 3, a clear bit 31 of the big-endian first word sets bit 12; a set bit 31 puts bit 12 in `sts_clr`.
- R8: If the expected length is nonzero and the reply is long enough, bytes 2k (high) and 2k+1 (low) form register 7−k, held at `rsp_word[16n+15:16n]` for register n. Reply byte i sits at `card_rsp_data[127-8i -: 8]`, and bytes at positions at or beyond `card_rsp_len` read as zero.
- R9: A completion without timeout for index 12 sets bits 0 and 2; any other such completion sets bit 0 only.
- R10: At every card completion, command type 3 pulses `xfer_start`, with `xfer_dir` equal to bit 15; any other type pulses `xfer_stop`. The two never pulse together.
- R11: Status masks appear only as a one-cycle `cmd_done` pulse, in the cycle after `card_rsp_vld` is sampled while `busy` is high, never before the card answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; commands are dropped while low |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 16 | Command word |
| cmd_arg | input | 32 | Command argument |
| busy | output | 1 | A command awaits the card reply |
| card_req | output | 1 | One-cycle request to the card side |
| card_idx | output | 6 | Command index presented with the request |
| card_arg | output | 32 | Argument presented with the request |
| card_rsp_vld | input | 1 | Card reply strobe |
| card_rsp_len | input | 5 | Number of valid reply bytes |
| card_rsp_data | input | 128 | Reply bytes, byte 0 in the top bits |
| cmd_done | output | 1 | One-cycle completion pulse |
| sts_set | output | 16 | Status bits to set, valid with cmd_done |
| sts_clr | output | 16 | Status bits to clear, valid with cmd_done |
| rsp_word | output | 128 | Eight response registers, register n at bits 16n+15:16n |
| xfer_start | output | 1 | Data transfer start pulse |
| xfer_stop | output | 1 | Data transfer end pulse |
| xfer_dir | output | 1 | Transfer direction, 1 = card to host |

## Verification
The command word is driven with every response code, including an unsupported one, with and without the busy flag, so that promotion, the length rule and the error-mask test are each seen to act on their own. The reply lengths are exact, one short and longer than needed. These three cases separate the timeout path from the capture path and show that stray bytes past the count are masked. Index 12, the init pseudo-command, an index 0 command without the init flag, and both transfer directions separate the special completions from the plain one. Writes with the enable low and writes during an outstanding command show that neither a request nor a clearing of the held response leaks through.

// File: rtl/sdcmd_pkg.sv
`timescale 1ns/1ps
package sdcmd_pkg;

  localparam int unsigned STS_W    = 16;
  localparam int unsigned STS_EOC  = 0;
  localparam int unsigned STS_STOP = 2;
  localparam int unsigned STS_TOUT = 7;
  localparam int unsigned STS_OCRB = 12;
  localparam int unsigned STS_CERR = 14;

  typedef enum logic [2:0] {
    RK_NONE, RK_R1, RK_R1B, RK_R2, RK_R3, RK_R6
  } rsp_kind_e;

  typedef enum logic {ST_IDLE, ST_WAIT} ctrl_state_e;

  typedef struct packed {
    logic       dir;
    logic [1:0] ctype;
    logic       busy;
    logic [2:0] rcode;
    logic       init;
    logic [5:0] idx;
  } cmd_fields_t;

  function automatic cmd_fields_t split_word(input logic [15:0] w);
    cmd_fields_t f;
    f.idx   = w[5:0];
    f.init  = w[7];
    f.rcode = w[10:8];
    f.busy  = w[11];
    f.ctype = w[13:12];
    f.dir   = w[15];
    return f;
  endfunction

  function automatic rsp_kind_e classify(input logic [2:0] code, input logic busy);
    case (code)
      3'd1:    return busy ? RK_R1B : RK_R1;
      3'd2:    return RK_R2;
      3'd3:    return RK_R3;
      3'd6:    return RK_R6;
      default: return RK_NONE;
    endcase
  endfunction

  function automatic logic [4:0] expected_len(input rsp_kind_e k);
    case (k)
      RK_NONE: return 5'd0;
      RK_R2:   return 5'd16;
      default: return 5'd4;
    endcase
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
`timescale 1ns/1ps
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int unsigned   LEN_W      = 5,
  parameter int unsigned   STOP_IDX   = 12,
  parameter logic [1:0]    XFER_CTYPE = 2'd3
) (
  input  logic [15:0]      word,
  output logic [5:0]       idx,
  output rsp_kind_e        kind,
  output logic [LEN_W-1:0] explen,
  output logic             bypass,
  output logic             is_xfer,
  output logic             is_stop,
  output logic             dir
);
  cmd_fields_t f;
  logic        unused_rsv;

  assign f          = split_word(word);
  assign unused_rsv = ^{word[14], word[6]};
  assign idx        = f.idx;
  assign kind       = classify(f.rcode, f.busy);
  assign explen     = LEN_W'(expected_len(kind));
  assign bypass     = f.init && (f.idx == 6'd0);
  assign is_xfer    = (f.ctype == XFER_CTYPE);
  assign is_stop    = (f.idx == 6'(STOP_IDX));
  assign dir        = f.dir;
endmodule

// File: rtl/sdcmd_eval.sv
`timescale 1ns/1ps
module sdcmd_eval
  import sdcmd_pkg::*;
#(
  parameter int unsigned  RSP_BYTES   = 16,
  parameter int unsigned  LEN_W       = 5,
  parameter logic [31:0]  R1_ERR_MASK = 32'hFDF9_0000,
  localparam int unsigned RSP_W       = RSP_BYTES * 8,
  localparam int unsigned NREG        = RSP_BYTES / 2
) (
  input  rsp_kind_e        kind,
  input  logic [LEN_W-1:0] explen,
  input  logic             is_stop,
  input  logic [LEN_W-1:0] rsp_len,
  input  logic [RSP_W-1:0] rsp_data,
  output logic [STS_W-1:0] e_set,
  output logic [STS_W-1:0] e_clr,
  output logic [RSP_W-1:0] e_rsp
);
  logic        short_rsp;
  logic        capture;
  logic [31:0] first_word;
  logic [RSP_W-1:0] pairs;

  assign short_rsp  = (rsp_len < explen);
  assign capture    = (explen != '0) && !short_rsp;
  assign first_word = rsp_data[RSP_W-1 -: 32];

  for (genvar k = 0; k < NREG; k++) begin : g_pair
    logic [7:0] hi_b, lo_b;
    assign hi_b = (LEN_W'(2*k)   < rsp_len) ? rsp_data[RSP_W-1-16*k -: 8] : 8'h00;
    assign lo_b = (LEN_W'(2*k+1) < rsp_len) ? rsp_data[RSP_W-9-16*k -: 8] : 8'h00;
    assign pairs[(NREG-1-k)*16 +: 16] = {hi_b, lo_b};
  end

  assign e_rsp = capture ? pairs : '0;

  always_comb begin
    e_set           = '0;
    e_clr           = '0;
    e_clr[STS_CERR] = 1'b1;
    if (short_rsp) begin
      e_set[STS_TOUT] = 1'b1;
    end else begin
      e_set[STS_EOC]  = 1'b1;
      e_set[STS_STOP] = is_stop;
      if ((kind == RK_R1 || kind == RK_R1B) && ((first_word & R1_ERR_MASK) != 32'd0)) begin
        e_set[STS_CERR] = 1'b1;
        e_clr[STS_CERR] = 1'b0;
      end
      if (kind == RK_R3) begin
        if (first_word[31]) e_clr[STS_OCRB] = 1'b1;
        else                e_set[STS_OCRB] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdcmd_ctrl.sv
`timescale 1ns/1ps
module sdcmd_ctrl
  import sdcmd_pkg::*;
#(
  parameter int unsigned ARG_W = 32,
  parameter int unsigned LEN_W = 5,
  parameter int unsigned RSP_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             bypass,
  input  logic [5:0]       idx_in,
  input  logic [ARG_W-1:0] arg_in,
  input  rsp_kind_e        kind_in,
  input  logic [LEN_W-1:0] explen_in,
  input  logic             stop_in,
  input  logic             xfer_in,
  input  logic             dir_in,
  input  logic             rsp_vld,
  input  logic [STS_W-1:0] e_set,
  input  logic [STS_W-1:0] e_clr,
  input  logic [RSP_W-1:0] e_rsp,
  output logic             complete,
  output logic             busy,
  output logic             card_req,
  output logic [5:0]       card_idx,
  output logic [ARG_W-1:0] card_arg,
  output rsp_kind_e        h_kind,
  output logic [LEN_W-1:0] h_explen,
  output logic             h_stop,
  output logic             done,
  output logic [STS_W-1:0] sts_set,
  output logic [STS_W-1:0] sts_clr,
  output logic [RSP_W-1:0] rsp_word,
  output logic             xfer_start,
  output logic             xfer_stop,
  output logic             xfer_dir
);
  ctrl_state_e state;
  logic        h_xfer;

  assign busy     = (state == ST_WAIT);
  assign complete = busy && rsp_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      card_req   <= 1'b0;
      card_idx   <= '0;
      card_arg   <= '0;
      h_kind     <= RK_NONE;
      h_explen   <= '0;
      h_stop     <= 1'b0;
      h_xfer     <= 1'b0;
      done       <= 1'b0;
      sts_set    <= '0;
      sts_clr    <= '0;
      rsp_word   <= '0;
      xfer_start <= 1'b0;
      xfer_stop  <= 1'b0;
      xfer_dir   <= 1'b0;
    end else begin
      card_req   <= 1'b0;
      done       <= 1'b0;
      xfer_start <= 1'b0;
      xfer_stop  <= 1'b0;
      if (accept) begin
        rsp_word <= '0;
        if (bypass) begin
          done    <= 1'b1;
          sts_set <= STS_W'(1) << STS_EOC;
          sts_clr <= '0;
        end else begin
          state    <= ST_WAIT;
          card_req <= 1'b1;
          card_idx <= idx_in;
          card_arg <= arg_in;
          h_kind   <= kind_in;
          h_explen <= explen_in;
          h_stop   <= stop_in;
          h_xfer   <= xfer_in;
          xfer_dir <= dir_in;
        end
      end else if (complete) begin
        state      <= ST_IDLE;
        done       <= 1'b1;
        sts_set    <= e_set;
        sts_clr    <= e_clr;
        rsp_word   <= e_rsp;
        xfer_start <= h_xfer;
        xfer_stop  <= !h_xfer;
      end
    end
  end
endmodule

// File: rtl/sdcmd_issuer.sv
`timescale 1ns/1ps
module sdcmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int unsigned  ARG_W       = 32,
  parameter int unsigned  RSP_BYTES   = 16,
  parameter int unsigned  STOP_IDX    = 12,
  parameter logic [31:0]  R1_ERR_MASK = 32'hFDF9_0000,
  localparam int unsigned RSP_W       = RSP_BYTES * 8,
  localparam int unsigned LEN_W       = $clog2(RSP_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             cmd_wr,
  input  logic [15:0]      cmd_word,
  input  logic [ARG_W-1:0] cmd_arg,
  output logic             busy,
  output logic             card_req,
  output logic [5:0]       card_idx,
  output logic [ARG_W-1:0] card_arg,
  input  logic             card_rsp_vld,
  input  logic [LEN_W-1:0] card_rsp_len,
  input  logic [RSP_W-1:0] card_rsp_data,
  output logic             cmd_done,
  output logic [STS_W-1:0] sts_set,
  output logic [STS_W-1:0] sts_clr,
  output logic [RSP_W-1:0] rsp_word,
  output logic             xfer_start,
  output logic             xfer_stop,
  output logic             xfer_dir
);
  logic             ev_accept;
  logic             ev_complete;
  logic [5:0]       d_idx;
  rsp_kind_e        d_kind;
  logic [LEN_W-1:0] d_explen;
  logic             d_bypass, d_xfer, d_stop, d_dir;
  rsp_kind_e        h_kind;
  logic [LEN_W-1:0] h_explen;
  logic             h_stop;
  logic [STS_W-1:0] e_set, e_clr;
  logic [RSP_W-1:0] e_rsp;

  assign ev_accept = cmd_wr && ctrl_en && !busy;

  sdcmd_decode #(.LEN_W(LEN_W), .STOP_IDX(STOP_IDX), .XFER_CTYPE(2'd3)) u_dec (
    .word(cmd_word), .idx(d_idx), .kind(d_kind), .explen(d_explen),
    .bypass(d_bypass), .is_xfer(d_xfer), .is_stop(d_stop), .dir(d_dir)
  );

  sdcmd_eval #(.RSP_BYTES(RSP_BYTES), .LEN_W(LEN_W), .R1_ERR_MASK(R1_ERR_MASK)) u_eval (
    .kind(h_kind), .explen(h_explen), .is_stop(h_stop),
    .rsp_len(card_rsp_len), .rsp_data(card_rsp_data),
    .e_set(e_set), .e_clr(e_clr), .e_rsp(e_rsp)
  );

  sdcmd_ctrl #(.ARG_W(ARG_W), .LEN_W(LEN_W), .RSP_W(RSP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .accept(ev_accept), .bypass(d_bypass),
    .idx_in(d_idx), .arg_in(cmd_arg), .kind_in(d_kind), .explen_in(d_explen),
    .stop_in(d_stop), .xfer_in(d_xfer), .dir_in(d_dir),
    .rsp_vld(card_rsp_vld), .e_set(e_set), .e_clr(e_clr), .e_rsp(e_rsp),
    .complete(ev_complete), .busy(busy), .card_req(card_req),
    .card_idx(card_idx), .card_arg(card_arg),
    .h_kind(h_kind), .h_explen(h_explen), .h_stop(h_stop),
    .done(cmd_done), .sts_set(sts_set), .sts_clr(sts_clr), .rsp_word(rsp_word),
    .xfer_start(xfer_start), .xfer_stop(xfer_stop), .xfer_dir(xfer_dir)
  );
endmodule

// File: rtl/sdcmd_chk.sv
`timescale 1ns/1ps
module sdcmd_chk #(
  parameter int unsigned RSP_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_en,
  input logic             cmd_wr,
  input logic [15:0]      cmd_word,
  input logic             busy,
  input logic             card_req,
  input logic             card_rsp_vld,
  input logic             cmd_done,
  input logic [15:0]      sts_set,
  input logic [RSP_W-1:0] rsp_word,
  input logic             xfer_start,
  input logic             xfer_stop,
  input logic             ev_accept,
  input logic             ev_complete
);
  AST_REQ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    card_req |=> !card_req); // R3

  AST_RSP_CLEARED_AT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    card_req |-> (rsp_word == '0)); // R3

  AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ctrl_en && !busy) |=> (!card_req && !cmd_done)); // R2

  AST_INIT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && cmd_word[7] && cmd_word[5:0] == 6'd0) |=>
      (cmd_done && !card_req && sts_set == 16'h0001)); // R4

  AST_EOC_OR_TOUT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> ($countones({sts_set[0], sts_set[7]}) == 1)); // R5

  AST_TOUT_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && sts_set[7]) |-> (rsp_word == '0)); // R5

  AST_STOP_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && sts_set[2]) |-> sts_set[0]); // R9

  AST_XFER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({xfer_start, xfer_stop}) <= 1); // R10

  AST_DONE_AFTER_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && card_rsp_vld) |=> (cmd_done && !busy)); // R11

  AST_DONE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_done) |-> $past(ev_complete || ev_accept)); // R11
endmodule

bind sdcmd_issuer sdcmd_chk #(.RSP_W(RSP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cmd_wr(cmd_wr),
  .cmd_word(cmd_word), .busy(busy), .card_req(card_req),
  .card_rsp_vld(card_rsp_vld), .cmd_done(cmd_done), .sts_set(sts_set),
  .rsp_word(rsp_word), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
  .ev_accept(ev_accept), .ev_complete(ev_complete)
);

// File: tb/test_sdcmd_issuer.sv
`timescale 1ns/1ps
module test_sdcmd_issuer;

  typedef struct packed {
    logic [15:0]  set;
    logic [15:0]  clr;
    logic [127:0] rsp;
    logic         xs;
    logic         xp;
    logic         xd;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctrl_en = 1'b0;
  logic         cmd_wr = 1'b0;
  logic [15:0]  cmd_word = '0;
  logic [31:0]  cmd_arg = '0;
  logic         busy, card_req;
  logic [5:0]   card_idx;
  logic [31:0]  card_arg;
  logic         card_rsp_vld = 1'b0;
  logic [4:0]   card_rsp_len = '0;
  logic [127:0] card_rsp_data = '0;
  logic         cmd_done;
  logic [15:0]  sts_set, sts_clr;
  logic [127:0] rsp_word;
  logic         xfer_start, xfer_stop, xfer_dir;

  int checks = 0;
  int failures = 0;
  exp_t  sbq[$];
  string tagq[$];

  always #4 clk = ~clk;

  sdcmd_issuer i_sdcmd_issuer (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .cmd_wr(cmd_wr),
    .cmd_word(cmd_word), .cmd_arg(cmd_arg), .busy(busy), .card_req(card_req),
    .card_idx(card_idx), .card_arg(card_arg), .card_rsp_vld(card_rsp_vld),
    .card_rsp_len(card_rsp_len), .card_rsp_data(card_rsp_data),
    .cmd_done(cmd_done), .sts_set(sts_set), .sts_clr(sts_clr),
    .rsp_word(rsp_word), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
    .xfer_dir(xfer_dir)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [15:0] w, input int n, input logic [127:0] d);
    exp_t e;
    int need;
    int rc;
    logic [31:0] st;
    logic [7:0] b [16];
    for (int i = 0; i < 16; i++) b[i] = (i < n) ? d[127-8*i -: 8] : 8'h00;
    e  = '0;
    rc = int'(w[10:8]);
    if (rc == 2) need = 16;
    else if (rc == 1 || rc == 3 || rc == 6) need = 4;
    else need = 0;
    e.clr = 16'h4000;
    if (w[13:12] == 2'b11) begin e.xs = 1'b1; e.xd = w[15]; end
    else e.xp = 1'b1;
    if (n < need) begin
      e.set = 16'h0080;
      return e;
    end
    e.set = (w[5:0] == 6'd12) ? 16'h0005 : 16'h0001;
    st = {b[0], b[1], b[2], b[3]};
    if (rc == 1 && (st & 32'hFDF9_0000) != 0) begin
      e.set = e.set | 16'h4000;
      e.clr = 16'h0000;
    end
    if (rc == 3) begin
      if (st[31]) e.clr = e.clr | 16'h1000;
      else        e.set = e.set | 16'h1000;
    end
    if (need > 0)
      for (int r = 0; r < 8; r++) e.rsp[16*r +: 16] = {b[14-2*r], b[15-2*r]};
    return e;
  endfunction

  // Monitor: pops one expected item per completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_done) begin
        if (sbq.size() == 0) begin
          checks++; failures++;
          $display("FAIL R11 completion with nothing outstanding actual=%0h expected=0", sts_set);
        end else begin
          exp_t  e;
          string t;
          e = sbq.pop_front();
          t = tagq.pop_front();
          chk(sts_set == e.set, {t, " sts_set"}, 128'(sts_set), 128'(e.set));
          chk(sts_clr == e.clr, {t, " sts_clr"}, 128'(sts_clr), 128'(e.clr));
          chk(rsp_word == e.rsp, {t, " R8 rsp_word"}, rsp_word, e.rsp);
          chk({xfer_start, xfer_stop} == {e.xs, e.xp}, {t, " R10 xfer pulses"},
              128'({xfer_start, xfer_stop}), 128'({e.xs, e.xp}));
          if (e.xs) chk(xfer_dir == e.xd, {t, " R10 xfer_dir"}, 128'(xfer_dir), 128'(e.xd));
        end
      end else if (xfer_start || xfer_stop) begin
        checks++; failures++;
        $display("FAIL R10 transfer pulse without completion actual=%0b%0b expected=00", xfer_start, xfer_stop);
      end
    end
  end

  // Driver: issues a command, plays the card, pushes the expected result
  task automatic issue(input string tag, input logic [15:0] w, input logic [31:0] a,
                       input int n, input logic [127:0] d, input int lat, input bit poke);
    @(negedge clk);
    cmd_word = w; cmd_arg = a; cmd_wr = 1'b1;
    if (w[7] && w[5:0] == 6'd0) begin
      sbq.push_back('{set: 16'h0001, clr: 16'h0000, rsp: '0, xs: 1'b0, xp: 1'b0, xd: 1'b0});
      tagq.push_back({tag, " R4"});
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(card_req == 1'b0, "R4 no card request on init", 128'(card_req), 128'(0));
      chk(cmd_done == 1'b1, "R4 init completes next cycle", 128'(cmd_done), 128'(1));
    end else begin
      @(negedge clk);
      cmd_wr = 1'b0;
      chk(card_req == 1'b1, {tag, " R3 card_req"}, 128'(card_req), 128'(1));
      chk(card_idx == w[5:0] && card_arg == a, {tag, " R1 R3 idx/arg"},
          128'({card_idx, card_arg}), 128'({w[5:0], a}));
      chk(rsp_word == '0, {tag, " R3 response cleared"}, rsp_word, '0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        if (i == 0) begin
          chk(card_req == 1'b0, {tag, " R3 single-cycle request"}, 128'(card_req), 128'(0));
          if (poke) begin
            cmd_word = 16'h0111; cmd_arg = 32'hDEAD_BEEF; cmd_wr = 1'b1;
          end
        end else if (i == 1 && poke) begin
          cmd_wr = 1'b0;
          chk(card_req == 1'b0, "R2 write while busy makes no request", 128'(card_req), 128'(0));
        end
      end
      card_rsp_len = 5'(n); card_rsp_data = d; card_rsp_vld = 1'b1;
      sbq.push_back(model(w, n, d));
      tagq.push_back(tag);
      @(negedge clk);
      card_rsp_vld = 1'b0; card_rsp_data = '0; card_rsp_len = '0;
      chk(cmd_done == 1'b1, {tag, " R11 done one cycle after reply"}, 128'(cmd_done), 128'(1));
    end
    @(negedge clk);
    chk(cmd_done == 1'b0 && busy == 1'b0, {tag, " R11 single done pulse"},
        128'({cmd_done, busy}), 128'(0));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, card_req, cmd_done, xfer_start, xfer_stop} == 5'b0, "R11 reset outputs idle",
        128'({busy, card_req, cmd_done, xfer_start, xfer_stop}), 0);
    chk(rsp_word == '0, "R8 reset response zero", rsp_word, 0);
    ctrl_en = 1'b1;

    issue("R4 init pseudo", 16'h0080, 32'h0, 0, '0, 0, 1'b0);
    issue("R6 R1 clean", 16'h0111, 32'h0000_1234, 4, {32'h0000_0900, {24{4'hA}}}, 2, 1'b0);
    issue("R6 R5 R1b error", 16'h0911, 32'h1, 4, {32'h0040_0000, 96'h0}, 1, 1'b0);
    issue("R9 stop index", 16'h090C, 32'h0, 4, {32'h0000_0000, 96'h0}, 0, 1'b0);
    issue("R5 R1 short", 16'h0111, 32'h2, 3, {32'hFFFF_FFFF, 96'h0}, 3, 1'b0);
    issue("R8 R2 long", 16'h0202, 32'h0, 16, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 5, 1'b0);
    issue("R5 R2 short", 16'h0209, 32'h0, 15, 128'h0011_2233_4455_6677_8899_AABB_CCDD_EEFF, 1, 1'b0);
    issue("R7 R3 busy", 16'h0329, 32'h00FF_8000, 4, {32'h00FF_8000, 96'h0}, 2, 1'b0);
    issue("R7 R3 ready", 16'h0329, 32'h00FF_8000, 4, {32'h80FF_8000, 96'h0}, 2, 1'b0);
    issue("R8 R6 six bytes", 16'h0603, 32'h0, 6, {48'h1234_0500_ABCD, 80'h0}, 1, 1'b0);

    held = rsp_word;
    @(negedge clk);
    ctrl_en = 1'b0;
    cmd_word = 16'h0111; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk(card_req == 1'b0 && busy == 1'b0, "R2 disabled write no request",
        128'({card_req, busy}), 0);
    repeat (2) @(negedge clk);
    chk(rsp_word == held, "R2 disabled write keeps response", rsp_word, held);
    ctrl_en = 1'b1;

    issue("R1 no-response idx0", 16'h0000, 32'h0, 4, {32'h1111_2222, 96'h0}, 1, 1'b0);
    issue("R1 unsupported code", 16'h4507, 32'h0, 16, {128{1'b1}}, 0, 1'b0);
    issue("R10 read transfer", 16'hB111, 32'h400, 4, {32'h0000_0900, 96'h0}, 2, 1'b0);
    issue("R10 write transfer", 16'h3118, 32'h800, 4, {32'h0000_0900, 96'h0}, 1, 1'b0);
    issue("R2 busy poke", 16'h0111, 32'h55, 4, {32'h0000_0B00, 96'h0}, 4, 1'b0);
    issue("R2 R11 busy poke", 16'h0310, 32'h66, 4, {32'h0000_0001, 96'h0}, 4, 1'b1);

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R11 all expected completions seen", 128'(sbq.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule